// File: doc/BRIEF.md
# Mixed-Policy Control and Status Word

This block is one 32-bit software-visible register. Its bits follow six different access rules. A two-bit mode field is read-write. A two-bit status field shows live hardware inputs. A go bit is write-only and turns a write of 1 into a single-cycle strobe. An event flag is cleared by writing 1 to it. An overflow flag is cleared by reading it. A force bit is set by writing 1 to it.

Software reaches the word over a plain synchronous strobe bus with a select, a write enable, a read enable, 32 bits of write data and 32 bits of registered read data. Hardware raises the event flag and the overflow flag with one-cycle pulses. When a hardware event and a software clear arrive in the same cycle, the event wins.

The read word has this layout:

| Bits | Contents |
|------|----------|
| [1:0] | mode |
| [3:2] | hardware status |
| [4] | go |
| [5] | event flag |
| [6] | overflow flag |
| [7] | force |
| [31:8] | reserved |

A write access is `sel & wr_en`. A read access is `sel & rd_en`.

Top module: `mixreg_csr`

## Requirements
- R1: After reset the mode output is 0, the go strobe is 0 and the force output is 0. A read then returns 0x20 plus the live status in bits [3:2], because the event flag resets to 1 and the overflow flag resets to 0.
- R2: A write stores bits [1:0] of the write data into the mode field. The mode output shows the new value from the next cycle, and reads return it.
- R3: Bits [3:2] read back as the current value of `hw_status_i`. Writes to those bits have no effect.
- R4: A write with bit 4 set drives `go_pulse_o` high for exactly the one cycle after the write strobe. Bit 4 always reads as 0.
- R5: Bit 5, the event flag, becomes 1 on an `evt_pulse_i` pulse. A write with bit 5 set clears it. A write with bit 5 clear leaves it unchanged.
- R6: If `evt_pulse_i` arrives in the same cycle as a write that clears bit 5, the event flag stays 1.
- R7: Bit 6, the overflow flag, becomes 1 on an `ovf_pulse_i` pulse. A read returns the flag and clears it in the same step, so the next read returns 0. Writes have no effect on this flag.
- R8: If `ovf_pulse_i` arrives in the same cycle as a read, that read returns the old value and the overflow flag stays 1.
- R9: Bit 7, the force bit, is set by a write with bit 7 set. A write with bit 7 clear leaves it unchanged. `force_o` shows the bit.
- R10: Read data appears in the cycle after the read strobe and is 0 in every other cycle. Bits [31:8] always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write enable, qualified by `sel` |
| rd_en | input | 1 | Read enable, qualified by `sel` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| hw_status_i | input | 2 | Live hardware status shown in bits [3:2] |
| evt_pulse_i | input | 1 | Hardware event pulse that sets the event flag |
| ovf_pulse_i | input | 1 | Hardware overflow pulse that sets the overflow flag |
| mode_o | output | 2 | Stored mode field |
| go_pulse_o | output | 1 | One-cycle strobe from a write of 1 to bit 4 |
| force_o | output | 1 | Force bit, set by software writing 1 |

## Verification
A hardware set and a software clear can land on the same flag in the same cycle. This happens in two ways: an event pulse with a write-1-to-clear of the event flag, and an overflow pulse with a clearing read. The bench raises the pulse and the bus strobe on the same clock edge. It then judges the result by reading the word again: the flag must still be 1. For the overflow case, the racing read must itself return the old value, and a third read after no new pulse must return 0.

// File: rtl/mixreg_pkg.sv
package mixreg_pkg;
  localparam int DATA_W   = 32;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 2;
  localparam int STAT_LSB = 2;
  localparam int STAT_W   = 2;
  localparam int GO_BIT   = 4;
  localparam int EVT_BIT  = 5;
  localparam int OVF_BIT  = 6;
  localparam int FRC_BIT  = 7;
  localparam int USED_W   = 8;
  localparam int NFLAG    = 3;
  localparam int FL_EVT   = 0;
  localparam int FL_OVF   = 1;
  localparam int FL_FRC   = 2;
endpackage

// File: rtl/mixreg_flag.sv
module mixreg_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o & ~clr_i;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= q_d;
  end

  // R6 and R8: a hardware set beats a clear that lands in the same cycle
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/mixreg_rdmux.sv
module mixreg_rdmux
  import mixreg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              evt_i,
  input  logic              ovf_i,
  input  logic              frc_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] word;
  logic [DW-1:0] rdata_d;

  always_comb begin
    word = '0;
    word[MODE_LSB +: MODE_W] = mode_i;
    word[STAT_LSB +: STAT_W] = stat_i;
    word[EVT_BIT]            = evt_i;
    word[OVF_BIT]            = ovf_i;
    word[FRC_BIT]            = frc_i;
    rdata_d = rd_i ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rdata_d;
  end

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_o == '0));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (rdata_o[DW-1:USED_W] == '0));
  a_r4_go_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !rdata_o[GO_BIT]);
endmodule

// File: rtl/mixreg_csr.sv
module mixreg_csr
  import mixreg_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int MW   = MODE_W,
  parameter int SW   = STAT_W,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [SW-1:0] hw_status_i,
  input  logic          evt_pulse_i,
  input  logic          ovf_pulse_i,
  output logic [MW-1:0] mode_o,
  output logic          go_pulse_o,
  output logic          force_o
);
  localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'(1 << FL_EVT);

  // asynchronous assert, synchronous release
  logic [SYNC-1:0] sync_q;
  logic            rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], 1'b1};
  end
  assign rst_i_n = sync_q[SYNC-1];

  logic wr, rd;
  assign wr = sel & wr_en;
  assign rd = sel & rd_en;

  // mode field, read-write
  logic [MW-1:0] mode_d;
  always_comb begin
    mode_d = mode_o;
    if (wr) mode_d = wdata[MODE_LSB +: MW];
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_o <= '0;
    else          mode_o <= mode_d;
  end

  // go strobe, write-only, no stored state
  logic go_d;
  assign go_d = wr & wdata[GO_BIT];
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) go_pulse_o <= 1'b0;
    else          go_pulse_o <= go_d;
  end

  // sticky flags: event (W1C), overflow (clear on read), force (W1S)
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
  always_comb begin
    fl_set         = '0;
    fl_clr         = '0;
    fl_set[FL_EVT] = evt_pulse_i;
    fl_clr[FL_EVT] = wr & wdata[EVT_BIT];
    fl_set[FL_OVF] = ovf_pulse_i;
    fl_clr[FL_OVF] = rd;
    fl_set[FL_FRC] = wr & wdata[FRC_BIT];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    mixreg_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
      .clk   (clk),
      .rst_n (rst_i_n),
      .set_i (fl_set[i]),
      .clr_i (fl_clr[i]),
      .q_o   (fl_q[i])
    );
  end

  assign force_o = fl_q[FL_FRC];

  mixreg_rdmux #(.DW(DW)) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_i    (rd),
    .mode_i  (mode_o),
    .stat_i  (hw_status_i),
    .evt_i   (fl_q[FL_EVT]),
    .ovf_i   (fl_q[FL_OVF]),
    .frc_i   (fl_q[FL_FRC]),
    .rdata_o (rdata)
  );

  a_r2_mode_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel && wr_en) |=> (mode_o == $past(wdata[MODE_LSB +: MW])));
  a_r2_mode_holds: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(sel && wr_en) |=> $stable(mode_o));
  a_r4_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (go_pulse_o && !$past(sel && wr_en && wdata[GO_BIT])) |-> 1'b0);
  a_r4_go_fires: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel && wr_en && wdata[GO_BIT]) |=> go_pulse_o);
  a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fl_q[FL_EVT] && !(sel && wr_en && wdata[EVT_BIT])) |=> fl_q[FL_EVT]);
  a_r8_read_keeps_on_event: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel && rd_en && ovf_pulse_i) |=> fl_q[FL_OVF]);
  a_r9_force_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    force_o |=> force_o);
endmodule

// File: tb/mixreg_csr_bench.sv
`timescale 1ns/1ps
module mixreg_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr_en, rd_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  hw_status_i;
  logic        evt_pulse_i, ovf_pulse_i;
  logic [1:0]  mode_o;
  logic        go_pulse_o, force_o;

  int total = 0;
  int fails = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  mixreg_csr u_mixreg_csr (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .hw_status_i(hw_status_i),
    .evt_pulse_i(evt_pulse_i), .ovf_pulse_i(ovf_pulse_i),
    .mode_o(mode_o), .go_pulse_o(go_pulse_o), .force_o(force_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: a read strobe seen at a posedge yields data checked at the next negedge
  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= sel & rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected read data", rdata, 32'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(rdata === it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  task automatic bus_write(input logic [31:0] d, input bit evt = 1'b0);
    sel = 1'b1; wr_en = 1'b1; wdata = d; evt_pulse_i = evt;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; wdata = '0; evt_pulse_i = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] exp, input string tag, input bit ovf = 1'b0);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    sel = 1'b1; rd_en = 1'b1; ovf_pulse_i = ovf;
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b0; ovf_pulse_i = 1'b0;
  endtask

  task automatic pulse_evt();
    evt_pulse_i = 1'b1; @(negedge clk); evt_pulse_i = 1'b0;
  endtask

  task automatic pulse_ovf();
    ovf_pulse_i = 1'b1; @(negedge clk); ovf_pulse_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    hw_status_i = 2'b10; evt_pulse_i = 1'b0; ovf_pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(mode_o == 2'b00, "R1 mode after reset", 32'(mode_o), 32'h0);
    chk(go_pulse_o == 1'b0, "R1 go after reset", 32'(go_pulse_o), 32'h0);
    chk(force_o == 1'b0, "R1 force after reset", 32'(force_o), 32'h0);
    bus_read(32'h0000_0028, "R1 reset read");
    // R10 idle cycle after the read
    @(negedge clk);
    chk(rdata == 32'h0, "R10 idle rdata", rdata, 32'h0);

    // R2 read-write mode
    bus_write(32'h0000_0002);
    chk(mode_o == 2'b10, "R2 mode output", 32'(mode_o), 32'h2);
    bus_read(32'h0000_002A, "R2 mode readback");

    // R3/R7/R10 writes to status, overflow and reserved bits are ignored
    bus_write(32'hFFFF_FF4C);
    bus_read(32'h0000_0028, "R3 R7 R10 ignored write bits");
    hw_status_i = 2'b01;
    @(negedge clk);
    bus_read(32'h0000_0024, "R3 live status");

    // R4 go strobe
    bus_write(32'h0000_0010);
    chk(go_pulse_o == 1'b1, "R4 go high after write", 32'(go_pulse_o), 32'h1);
    @(negedge clk);
    chk(go_pulse_o == 1'b0, "R4 go one cycle only", 32'(go_pulse_o), 32'h0);
    bus_read(32'h0000_0024, "R4 go reads zero");

    // R5 write-1-to-clear event flag
    bus_write(32'h0000_0000);
    bus_read(32'h0000_0024, "R5 write zero keeps flag");
    bus_write(32'h0000_0020);
    bus_read(32'h0000_0004, "R5 write one clears flag");
    pulse_evt();
    bus_read(32'h0000_0024, "R5 event sets flag");

    // R6 event races the clear
    bus_write(32'h0000_0020, 1'b1);
    bus_read(32'h0000_0024, "R6 event wins over clear");
    bus_write(32'h0000_0020);
    bus_read(32'h0000_0004, "R6 later clear works");

    // R7 clear on read
    pulse_ovf();
    bus_read(32'h0000_0044, "R7 first read sees flag");
    bus_read(32'h0000_0004, "R7 second read cleared");

    // R8 overflow races the read
    pulse_ovf();
    bus_read(32'h0000_0044, "R8 racing read old value", 1'b1);
    bus_read(32'h0000_0044, "R8 flag kept by event");
    bus_read(32'h0000_0004, "R8 cleared afterwards");

    // R9 write-1-to-set force
    bus_write(32'h0000_0080);
    chk(force_o == 1'b1, "R9 force set", 32'(force_o), 32'h1);
    bus_read(32'h0000_0084, "R9 force readback");
    bus_write(32'h0000_0000);
    chk(force_o == 1'b1, "R9 write zero keeps force", 32'(force_o), 32'h1);
    bus_read(32'h0000_0084, "R9 force still set");

    @(negedge clk);
    chk(rdata == 32'h0, "R10 idle after reads", rdata, 32'h0);
    chk(sb_q.size() == 0, "R10 all reads returned", 32'(sb_q.size()), 32'h0);
    finish_run();
  end
endmodule